// File: doc/BRIEF.md
# Received Frame Header Mismatch Monitor

This block inspects the four header bytes of each received LAPS frame: address, control, SAPI low and SAPI high. It compares each byte with an expected value that software can program. A receive framer outside the block presents the four bytes together with a one-cycle header-valid strobe. When a byte differs from its expected value, the block sets that field's own sticky flag in a status byte. A flag stays set until software reads the status location, and that read clears it.

Software reaches the block through a small 8-bit register port. The port writes and reads back the four expected bytes and an interrupt-enable mask, and it reads the status. The read data path is combinational from the selected register. A status read clears the flags on the clock edge that ends the read cycle. An interrupt line is high while any flag is set whose enable bit is also set.

Register offsets: 0 expected address, 1 expected control, 2 expected SAPI low, 3 expected SAPI high, 4 interrupt-enable mask, 5 status.

Top module: `hdr_chk_top`

## Requirements
- R1: After reset the expected bytes read back as 0x04 (offset 0), 0x03 (offset 1), 0x01 (offset 2) and 0xFE (offset 3). The mask (offset 4) and the status (offset 5) read 0, and irq is low.
- R2: Status bit 0 sets on the clock edge of a header-valid cycle in which the received address byte differs from the expected address.
- R3: Status bit 1 sets on the clock edge of a header-valid cycle in which the received control byte differs from the expected control byte.
- R4: Status bit 2 sets on a mismatch of the SAPI low byte, and bit 3 sets on a mismatch of the SAPI high byte. Status bits 7 to 4 always read 0.
- R5: A status bit that is set stays set through later header-valid cycles whose bytes all match, until the status is read.
- R6: A read at offset 5 returns the current status in the same cycle and clears all flags on the clock edge that ends that cycle.
- R7: When a mismatch arrives in the same cycle as a status read, the read returns the old flags and the new mismatch bit remains set afterwards.
- R8: Header bytes presented while header-valid is low change no status bit.
- R9: A write at offsets 0 to 3 replaces that expected byte, which then reads back. The comparison of later headers uses the new value.
- R10: The mask at offset 4 keeps its low four bits, and bits 7 to 4 read 0. irq equals the OR over the four status bits, each ANDed with its mask bit.
- R11: A write at offset 5 has no effect, and reads at offsets 6 and 7 return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| hdrValid | input | 1 | Header bytes valid this cycle |
| hdrAddr | input | 8 | Received address byte |
| hdrCtrl | input | 8 | Received control byte |
| hdrSapiLo | input | 8 | Received SAPI low byte |
| hdrSapiHi | input | 8 | Received SAPI high byte |
| regAddr | input | 3 | Register offset |
| regWrEn | input | 1 | Register write strobe |
| regRdEn | input | 1 | Register read strobe (status read clears) |
| regWrData | input | 8 | Register write data |
| regRdData | output | 8 | Register read data |
| irq | output | 1 | Masked OR of status flags |

## Verification
Headers are sent in four kinds. In the first, a single field is wrong, one field at a time, which shows whether each comparator drives its own flag bit. In the second, all four fields are wrong. In the third, the bytes match, which shows that the flags are sticky. In the fourth, the bytes are wrong but header-valid is low, which separates real comparisons from idle bus values. A mismatch that arrives in the same cycle as a status read shows that the clear and the set are ordered correctly. Headers sent before and after the expected bytes are reprogrammed show that the comparators use the register contents and not fixed constants. Different mask values, each with different flags set, check the interrupt gating bit by bit.

// File: rtl/hdr_chk_pkg.sv
package hdr_chk_pkg;
  localparam int DATA_W     = 8;
  localparam int NUM_FIELDS = 4;
  localparam int IDX_W      = $clog2(NUM_FIELDS);
  localparam int MASK_OFS   = NUM_FIELDS;
  localparam int STS_OFS    = NUM_FIELDS + 1;

  typedef enum logic [1:0] {
    RD_NONE = 2'd0,
    RD_EXP  = 2'd1,
    RD_MASK = 2'd2,
    RD_STS  = 2'd3
  } rd_sel_e;

  typedef struct packed {
    logic [NUM_FIELDS-1:0] expWr;
    logic                  maskWr;
    logic                  stsClr;
    rd_sel_e               rdSel;
    logic [IDX_W-1:0]      rdIdx;
  } ctrl_strobe_t;
endpackage

// File: rtl/hdr_chk_ctrl.sv
module hdr_chk_ctrl
  import hdr_chk_pkg::*;
#(
  parameter int ADDR_W = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              regWrEn,
  input  logic              regRdEn,
  output ctrl_strobe_t      strb
);
  localparam logic [ADDR_W-1:0] MASK_A = ADDR_W'(MASK_OFS);
  localparam logic [ADDR_W-1:0] STS_A  = ADDR_W'(STS_OFS);
  localparam logic [ADDR_W-1:0] NUM_A  = ADDR_W'(NUM_FIELDS);

  always_comb begin
    strb       = '0;
    strb.rdSel = RD_NONE;
    strb.rdIdx = regAddr[IDX_W-1:0];
    if (regAddr < NUM_A) begin
      strb.expWr[regAddr[IDX_W-1:0]] = regWrEn;
      strb.rdSel = RD_EXP;
    end else if (regAddr == MASK_A) begin
      strb.maskWr = regWrEn;
      strb.rdSel  = RD_MASK;
    end else if (regAddr == STS_A) begin
      // write at the status offset is dropped (R11)
      strb.stsClr = regRdEn;
      strb.rdSel  = RD_STS;
    end
  end

  // R9: at most one expected byte written per cycle
  p_one_wr_r9: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strb.expWr, strb.maskWr}));

  // R11: no write strobe can come from the status offset
  p_sts_nowr_r11: assert property (@(posedge clk) disable iff (!rstN)
    (regAddr == STS_A) |-> (strb.expWr == '0 && !strb.maskWr));
endmodule

// File: rtl/hdr_chk_dp.sv
module hdr_chk_dp
  import hdr_chk_pkg::*;
#(
  parameter logic [NUM_FIELDS*DATA_W-1:0] EXP_INIT = 32'hFE01_0304
) (
  input  logic                                clk,
  input  logic                                rstN,
  input  ctrl_strobe_t                        strb,
  input  logic                                hdrValid,
  input  logic [NUM_FIELDS-1:0][DATA_W-1:0]   hdrBytes,
  input  logic [DATA_W-1:0]                   wrData,
  output logic [DATA_W-1:0]                   rdData,
  output logic                                irq
);
  logic [NUM_FIELDS-1:0][DATA_W-1:0] expReg;
  logic [NUM_FIELDS-1:0]             cmpHit;
  logic [NUM_FIELDS-1:0]             status;
  logic [NUM_FIELDS-1:0]             maskReg;

  for (genvar i = 0; i < NUM_FIELDS; i++) begin : g_field
    always_ff @(posedge clk) begin
      if (!rstN)              expReg[i] <= EXP_INIT[i*DATA_W +: DATA_W];
      else if (strb.expWr[i]) expReg[i] <= wrData;
    end

    assign cmpHit[i] = hdrValid && (hdrBytes[i] != expReg[i]);

    // R2 R3 R4: a mismatching field raises its own flag
    p_capture_r2: assert property (@(posedge clk) disable iff (!rstN)
      (hdrValid && hdrBytes[i] != expReg[i]) |=> status[i]);
  end

  always_ff @(posedge clk) begin
    if (!rstN)            maskReg <= '0;
    else if (strb.maskWr) maskReg <= wrData[NUM_FIELDS-1:0];
  end

  // clear first, then OR in new hits so a same-cycle event survives
  always_ff @(posedge clk) begin
    if (!rstN) status <= '0;
    else       status <= (strb.stsClr ? '0 : status) | cmpHit;
  end

  assign irq = |(status & maskReg);

  always_comb begin
    unique case (strb.rdSel)
      RD_EXP:  rdData = expReg[strb.rdIdx];
      RD_MASK: rdData = DATA_W'(maskReg);
      RD_STS:  rdData = DATA_W'(status);
      default: rdData = '0;
    endcase
  end

  // R5: without a clear, no flag ever drops
  p_sticky_r5: assert property (@(posedge clk) disable iff (!rstN)
    !strb.stsClr |=> ((status & $past(status)) == $past(status)));

  // R6: a clear with no header leaves all flags low
  p_clear_r6: assert property (@(posedge clk) disable iff (!rstN)
    (strb.stsClr && !hdrValid) |=> (status == '0));

  // R8: no header, no new flags
  p_idle_r8: assert property (@(posedge clk) disable iff (!rstN)
    !hdrValid |=> ((status & ~$past(status)) == '0));
endmodule

// File: rtl/hdr_chk_top.sv
module hdr_chk_top
  import hdr_chk_pkg::*;
#(
  parameter int                           ADDR_W   = 3,
  parameter logic [NUM_FIELDS*DATA_W-1:0] EXP_INIT = 32'hFE01_0304
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              hdrValid,
  input  logic [7:0]        hdrAddr,
  input  logic [7:0]        hdrCtrl,
  input  logic [7:0]        hdrSapiLo,
  input  logic [7:0]        hdrSapiHi,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              regWrEn,
  input  logic              regRdEn,
  input  logic [7:0]        regWrData,
  output logic [7:0]        regRdData,
  output logic              irq
);
  ctrl_strobe_t                      strb;
  logic [NUM_FIELDS-1:0][DATA_W-1:0] hdrBytes;

  assign hdrBytes = {hdrSapiHi, hdrSapiLo, hdrCtrl, hdrAddr};

  hdr_chk_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .regAddr (regAddr),
    .regWrEn (regWrEn),
    .regRdEn (regRdEn),
    .strb    (strb)
  );

  hdr_chk_dp #(.EXP_INIT(EXP_INIT)) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strb     (strb),
    .hdrValid (hdrValid),
    .hdrBytes (hdrBytes),
    .wrData   (regWrData),
    .rdData   (regRdData),
    .irq      (irq)
  );

  // R1: interrupt low while in reset
  p_rst_irq_r1: assert property (@(posedge clk) !rstN |=> !irq);
endmodule

// File: tb/sim_hdr_chk_top.sv
module sim_hdr_chk_top;
  localparam int CLK_PERIOD = 10;

  typedef struct {
    bit         rdChk;
    logic [7:0] rdExp;
    logic       irqExp;
    string      tag;
  } exp_item_t;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       hdrValid = 1'b0;
  logic [7:0] hdrAddr = '0, hdrCtrl = '0, hdrSapiLo = '0, hdrSapiHi = '0;
  logic [2:0] regAddr = '0;
  logic       regWrEn = 1'b0, regRdEn = 1'b0;
  logic [7:0] regWrData = '0;
  logic [7:0] regRdData;
  logic       irq;

  int nCmp = 0;
  int nBad = 0;
  bit finished = 0;
  exp_item_t q[$];

  logic [7:0] mExp [4];
  logic [3:0] mMask;
  logic [3:0] mSts;

  always #(CLK_PERIOD/2) clk = ~clk;

  hdr_chk_top u0 (
    .clk(clk), .rstN(rstN), .hdrValid(hdrValid),
    .hdrAddr(hdrAddr), .hdrCtrl(hdrCtrl), .hdrSapiLo(hdrSapiLo), .hdrSapiHi(hdrSapiHi),
    .regAddr(regAddr), .regWrEn(regWrEn), .regRdEn(regRdEn),
    .regWrData(regWrData), .regRdData(regRdData), .irq(irq)
  );

  // monitor: one item per cycle, compared between edges
  initial begin
    forever begin
      @(negedge clk);
      if (q.size() > 0) begin
        exp_item_t it;
        it = q.pop_front();
        if (it.rdChk) begin
          nCmp++;
          if (regRdData !== it.rdExp) begin
            nBad++;
            $display("FAIL %s rdData actual=%02h expected=%02h", it.tag, regRdData, it.rdExp);
          end
        end
        nCmp++;
        if (irq !== it.irqExp) begin
          nBad++;
          $display("FAIL %s irq actual=%0b expected=%0b", it.tag, irq, it.irqExp);
        end
      end
    end
  end

  // driver: one bus cycle, with the model updated from the requirements
  task automatic slot(input bit hv, input logic [7:0] a, c, l, h,
                      input bit wr, input bit rd, input logic [2:0] ad,
                      input logic [7:0] wd, input string tag);
    exp_item_t it;
    logic [3:0] hit;
    @(posedge clk); #1;
    hdrValid = hv; hdrAddr = a; hdrCtrl = c; hdrSapiLo = l; hdrSapiHi = h;
    regWrEn = wr; regRdEn = rd; regAddr = ad; regWrData = wd;
    it.rdChk  = rd;
    it.tag    = tag;
    it.irqExp = |(mSts & mMask);
    if (ad < 3'd4)       it.rdExp = mExp[ad];
    else if (ad == 3'd4) it.rdExp = {4'b0, mMask};
    else if (ad == 3'd5) it.rdExp = {4'b0, mSts};
    else                 it.rdExp = 8'h00;
    q.push_back(it);
    hit = '0;
    if (hv) hit = {h != mExp[3], l != mExp[2], c != mExp[1], a != mExp[0]};
    mSts = ((rd && ad == 3'd5) ? 4'b0 : mSts) | hit;
    if (wr && ad < 3'd4)  mExp[ad] = wd;
    if (wr && ad == 3'd4) mMask = wd[3:0];
  endtask

  task automatic idle(input string tag);
    slot(0, 8'h00, 8'h00, 8'h00, 8'h00, 0, 0, 3'd6, 8'h00, tag);
  endtask
  task automatic rdReg(input logic [2:0] ad, input string tag);
    slot(0, 8'h00, 8'h00, 8'h00, 8'h00, 0, 1, ad, 8'h00, tag);
  endtask
  task automatic wrReg(input logic [2:0] ad, input logic [7:0] d, input string tag);
    slot(0, 8'h00, 8'h00, 8'h00, 8'h00, 1, 0, ad, d, tag);
  endtask
  task automatic hdr(input logic [7:0] a, c, l, h, input string tag);
    slot(1, a, c, l, h, 0, 0, 3'd6, 8'h00, tag);
  endtask

  task automatic finish();
    if (!finished) begin
      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nCmp, nBad);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    nCmp++; nBad++;
    $display("FAIL watchdog expired");
    finish();
  end

  initial begin
    mExp[0] = 8'h04; mExp[1] = 8'h03; mExp[2] = 8'h01; mExp[3] = 8'hFE;
    mMask = '0; mSts = '0;
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;

    // R1 reset values
    for (int k = 0; k < 6; k++) rdReg(3'(k), "R1");
    // R8 invalid header ignored
    slot(0, 8'hAA, 8'hBB, 8'hCC, 8'hDD, 0, 0, 3'd6, 8'h00, "R8");
    rdReg(3'd5, "R8");
    // R2 address mismatch, R6 read then clear
    hdr(8'h05, 8'h03, 8'h01, 8'hFE, "R2");
    rdReg(3'd5, "R2");
    rdReg(3'd5, "R6");
    // R3 control mismatch
    hdr(8'h04, 8'h13, 8'h01, 8'hFE, "R3");
    rdReg(3'd5, "R3");
    // R4 SAPI low / high, then all four
    hdr(8'h04, 8'h03, 8'h00, 8'hFE, "R4");
    rdReg(3'd5, "R4");
    hdr(8'h04, 8'h03, 8'h01, 8'h00, "R4");
    rdReg(3'd5, "R4");
    hdr(8'hFF, 8'hFF, 8'hFF, 8'hFF, "R4");
    rdReg(3'd5, "R4");
    rdReg(3'd5, "R6");
    // R5 sticky across matching headers
    hdr(8'h00, 8'h03, 8'h01, 8'hFE, "R5");
    for (int k = 0; k < 3; k++) hdr(8'h04, 8'h03, 8'h01, 8'hFE, "R5");
    rdReg(3'd5, "R5");
    // R7 mismatch coincident with read
    hdr(8'h04, 8'h00, 8'h01, 8'hFE, "R7");
    slot(1, 8'h04, 8'h00, 8'h00, 8'hFE, 0, 1, 3'd5, 8'h00, "R7");
    rdReg(3'd5, "R7");
    rdReg(3'd5, "R7");
    // R9 reprogram expected bytes
    wrReg(3'd0, 8'h10, "R9"); wrReg(3'd1, 8'h20, "R9");
    wrReg(3'd2, 8'h30, "R9"); wrReg(3'd3, 8'h40, "R9");
    for (int k = 0; k < 4; k++) rdReg(3'(k), "R9");
    hdr(8'h04, 8'h03, 8'h01, 8'hFE, "R9");
    rdReg(3'd5, "R9");
    hdr(8'h10, 8'h20, 8'h30, 8'h40, "R9");
    rdReg(3'd5, "R9");
    // R10 mask gating
    wrReg(3'd4, 8'hF5, "R10");
    rdReg(3'd4, "R10");
    hdr(8'h10, 8'h00, 8'h30, 8'h40, "R10");
    idle("R10");
    hdr(8'h00, 8'h20, 8'h30, 8'h40, "R10");
    idle("R10");
    rdReg(3'd5, "R10");
    idle("R10");
    wrReg(3'd4, 8'h08, "R10");
    hdr(8'h10, 8'h20, 8'h30, 8'h00, "R10");
    idle("R10");
    // R11 status not writable, unmapped reads zero
    wrReg(3'd5, 8'hFF, "R11");
    rdReg(3'd5, "R11");
    hdr(8'h10, 8'h20, 8'h30, 8'h40, "R11");
    wrReg(3'd5, 8'hFF, "R11");
    rdReg(3'd5, "R11");
    rdReg(3'd6, "R11");
    rdReg(3'd7, "R11");
    idle("end");
    @(negedge clk);
    @(negedge clk);
    finish();
  end
endmodule